// File: doc/BRIEF.md
# Debounced Wake-Up Event Controller

This block turns slow, noisy wake-up sources into clean notifications for a host processor. It watches three pins and an on-chip thermal early-warning flag. The pins are a push-button power-on input (active high), a test-jig input (active low) and a spare input whose active level is set by a configuration bit. Every pin is synchronised and then filtered, so that only a level held for a full debounce window counts as an event. Push-button presses are sorted into short and long presses.

Each accepted event sets a sticky cause bit in an 8-bit status word that a register interface reads. The bits stay set until the host pulses a clear strobe. Any event that arrives while no wake pulse is running starts one fixed-length pulse on the wake output. All timing is counted in ticks of a one-cycle millisecond strobe supplied by the surrounding logic, so the block runs from any system clock.

Top module: `wake_event_ctrl`

## Requirements
- R1: After reset, `wake_o` is 0 and all bits of `status_o` are 0.
- R2: A pin level is accepted only when it differs from the filtered level on `DEBOUNCE_MS` consecutive ticks, counted after a two-flop synchroniser. If the pin returns to the filtered level earlier, the count restarts and no event occurs.
- R3: An accepted transition of `jig_n_i` to 0 sets status bit 1.
- R4: The spare input is active low when `spare_act_low_i` is 1 and active high when it is 0. An accepted transition to its active level sets status bit 0.
- R5: A button press whose release is accepted before the press reaches `LONG_MS` ticks sets status bit 2. The bit is set at release and not during the press.
- R6: A button press held for `LONG_MS` ticks after acceptance sets status bit 3 while the button is still held. Its later release does not set bit 2.
- R7: A rising edge of the synchronised `therm_warn_i` sets status bit 6 and counts as a wake event, with no debounce.
- R8: An event that occurs while `wake_o` is low raises `wake_o` on the next clock edge. `wake_o` then falls on the `PULSE_MS`-th tick seen while it is high, and falls only on a tick.
- R9: An event that occurs while `wake_o` is high sets its status bit but neither restarts nor extends the pulse.
- R10: Status bits stay set until `clr_i` is sampled high, which clears them all. An event in the same cycle as `clr_i` still sets its bit. Bits 4, 5 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle strobe every millisecond |
| pwr_btn_i | input | 1 | Push-button pin, high when pressed |
| jig_n_i | input | 1 | Test-jig pin, low when active |
| spare_i | input | 1 | Spare wake pin |
| spare_act_low_i | input | 1 | 1 selects active-low spare, 0 active-high |
| therm_warn_i | input | 1 | Thermal early-warning flag |
| clr_i | input | 1 | Clears all status bits |
| wake_o | output | 1 | Wake pulse to the host |
| status_o | output | 8 | Sticky event causes: 0 spare, 1 jig, 2 short press, 3 long press, 6 thermal |

## Verification
On every cycle the assertions check several properties. Status bits never drop without a clear. The filtered button level and the end of the wake pulse change only after a tick. A pulse rises only after an event. The pulse is never cut short between ticks, and a thermal edge always lands in bit 6. Other behaviours can only be shown by the bench's scenarios against its cycle model: glitch rejection, the short/long boundary, spare polarity, the ignored extra event during a pulse, and set-over-clear priority.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned STATUS_W  = 8;
  localparam int unsigned N_FILT    = 3;
  localparam int unsigned N_SRC     = 4;
  localparam int unsigned SPARE_IDX = 0;
  localparam int unsigned JIG_IDX   = 1;
  localparam int unsigned BTN_IDX   = 2;
  localparam int unsigned THERM_IDX = 3;
  localparam int unsigned ST_SPARE  = 0;
  localparam int unsigned ST_JIG    = 1;
  localparam int unsigned ST_SHORT  = 2;
  localparam int unsigned ST_LONG   = 3;
  localparam int unsigned ST_THERM  = 6;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/wake_debounce.sv
module wake_debounce #(
  parameter int unsigned DB_TICKS = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic level_i,
  output logic state_o,
  output logic flip_o
);
  localparam int unsigned CW = $clog2(DB_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          differ;

  assign differ = level_i != state_o;
  assign flip_o = differ && tick_i && (cnt_q == CW'(DB_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      state_o <= 1'b0;
    end else if (!differ || flip_o) begin
      cnt_q   <= '0;
      state_o <= state_o ^ flip_o;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wake_press_class.sv
module wake_press_class #(
  parameter int unsigned LONG_TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pressed_i,
  input  logic release_i,
  output logic short_o,
  output logic long_o
);
  localparam int unsigned CW = $clog2(LONG_TICKS + 1);

  logic [CW-1:0] hold_q;
  logic          long_done_q;

  assign long_o  = pressed_i && tick_i && !long_done_q && (hold_q == CW'(LONG_TICKS - 1));
  // classification happens on release unless long already reported
  assign short_o = release_i && !long_done_q && !long_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      long_done_q <= 1'b0;
    end else if (!pressed_i) begin
      hold_q      <= '0;
      long_done_q <= 1'b0;
    end else if (long_o) begin
      long_done_q <= 1'b1;
    end else if (tick_i && !long_done_q) begin
      hold_q <= hold_q + 1'b1;
    end
  end
endmodule

// File: rtl/wake_pulse_gen.sv
module wake_pulse_gen #(
  parameter int unsigned PULSE_TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic evt_i,
  output logic wake_o
);
  localparam int unsigned CW = $clog2(PULSE_TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_o <= 1'b0;
      cnt_q  <= '0;
    end else if (wake_o) begin
      if (tick_i) begin
        if (cnt_q == CW'(PULSE_TICKS - 1)) begin
          wake_o <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else if (evt_i) begin
      wake_o <= 1'b1;
      cnt_q  <= '0;
    end
  end
endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
  import wake_pkg::*;
#(
  parameter int unsigned DEBOUNCE_MS = 30,
  parameter int unsigned LONG_MS     = 1000,
  parameter int unsigned PULSE_MS    = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_ms_i,
  input  logic                pwr_btn_i,
  input  logic                jig_n_i,
  input  logic                spare_i,
  input  logic                spare_act_low_i,
  input  logic                therm_warn_i,
  input  logic                clr_i,
  output logic                wake_o,
  output logic [STATUS_W-1:0] status_o
);
  logic [N_SRC-1:0]    raw_act, sync_act;
  logic [N_FILT-1:0]   filt, flip, rise;
  logic                therm_q, therm_evt;
  logic                short_evt, long_evt, any_evt;
  logic [STATUS_W-1:0] set_vec;

  // polarity folded in before synchronising: 1 means active
  assign raw_act[SPARE_IDX] = spare_i ^ spare_act_low_i;
  assign raw_act[JIG_IDX]   = ~jig_n_i;
  assign raw_act[BTN_IDX]   = pwr_btn_i;
  assign raw_act[THERM_IDX] = therm_warn_i;

  wake_sync #(.WIDTH(N_SRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_act),
    .q_o   (sync_act)
  );

  for (genvar g = 0; g < N_FILT; g++) begin : g_filt
    wake_debounce #(.DB_TICKS(DEBOUNCE_MS)) u_db (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_ms_i),
      .level_i(sync_act[g]),
      .state_o(filt[g]),
      .flip_o (flip[g])
    );
    assign rise[g] = flip[g] & ~filt[g];
  end

  wake_press_class #(.LONG_TICKS(LONG_MS)) u_press (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_ms_i),
    .pressed_i(filt[BTN_IDX]),
    .release_i(flip[BTN_IDX] & filt[BTN_IDX]),
    .short_o  (short_evt),
    .long_o   (long_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) therm_q <= 1'b0;
    else         therm_q <= sync_act[THERM_IDX];
  end
  assign therm_evt = sync_act[THERM_IDX] & ~therm_q;

  always_comb begin
    set_vec           = '0;
    set_vec[ST_SPARE] = rise[SPARE_IDX];
    set_vec[ST_JIG]   = rise[JIG_IDX];
    set_vec[ST_SHORT] = short_evt;
    set_vec[ST_LONG]  = long_evt;
    set_vec[ST_THERM] = therm_evt;
  end
  assign any_evt = |set_vec;

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= (clr_i ? '0 : status_o) | set_vec;
  end

  wake_pulse_gen #(.PULSE_TICKS(PULSE_MS)) u_pulse (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_ms_i),
    .evt_i (any_evt),
    .wake_o(wake_o)
  );
endmodule

// File: rtl/wake_event_ctrl_chk.sv
module wake_event_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_ms_i,
  input logic       clr_i,
  input logic       wake_o,
  input logic [7:0] status_o,
  input logic       btn_state_i,
  input logic       any_evt_i,
  input logic       therm_evt_i
);
  // R10
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (($past(status_o) & ~status_o) == 8'h00));

  // R2
  filt_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_ms_i |=> $stable(btn_state_i));

  // R8
  rise_on_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(any_evt_i));

  // R8
  fall_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wake_o) |-> $past(tick_ms_i));

  // R9
  no_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !tick_ms_i) |=> wake_o);

  // R7
  therm_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_evt_i |=> status_o[6]);
endmodule

bind wake_event_ctrl wake_event_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_ms_i  (tick_ms_i),
  .clr_i      (clr_i),
  .wake_o     (wake_o),
  .status_o   (status_o),
  .btn_state_i(filt[2]),
  .any_evt_i  (any_evt),
  .therm_evt_i(therm_evt)
);

// File: tb/wake_event_ctrl_tb_top.sv
`timescale 1ns/1ps
module wake_event_ctrl_tb_top;
  localparam int DB = 30;
  localparam int LG = 1000;
  localparam int PL = 10;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic btn = 1'b0, jig_n = 1'b1, spare = 1'b1, act_low = 1'b1, therm = 1'b0, clr = 1'b0;
  logic wake;
  logic [7:0] status;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wake_event_ctrl #(.DEBOUNCE_MS(DB), .LONG_MS(LG), .PULSE_MS(PL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_ms_i(tick), .pwr_btn_i(btn),
    .jig_n_i(jig_n), .spare_i(spare), .spare_act_low_i(act_low),
    .therm_warn_i(therm), .clr_i(clr), .wake_o(wake), .status_o(status)
  );

  int tcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin tcnt = 0; tick = 1'b0; end
    else begin tcnt = (tcnt + 1) % TDIV; tick = (tcnt == 0); end
  end

  // behavioural reference model
  int s1[4], s2[4], mf[3], mc[3];
  int m_hold, m_ldone, m_tprev, m_wk, m_pc, m_st;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin s1[i] = 0; s2[i] = 0; end
      for (int i = 0; i < 3; i++) begin mf[i] = 0; mc[i] = 0; end
      m_hold = 0; m_ldone = 0; m_tprev = 0; m_wk = 0; m_pc = 0; m_st = 0;
    end else begin
      int raw[4];
      int fl[3];
      int le, se, te, setv;
      raw[0] = int'(spare ^ act_low); raw[1] = int'(!jig_n);
      raw[2] = int'(btn); raw[3] = int'(therm);
      for (int i = 0; i < 3; i++)
        fl[i] = (s2[i] != mf[i] && tick && mc[i] == DB - 1) ? 1 : 0;
      le = (mf[2] == 1 && tick && m_ldone == 0 && m_hold == LG - 1) ? 1 : 0;
      se = (fl[2] == 1 && mf[2] == 1 && m_ldone == 0 && le == 0) ? 1 : 0;
      te = (s2[3] == 1 && m_tprev == 0) ? 1 : 0;
      setv = 0;
      if (fl[0] == 1 && mf[0] == 0) setv += 1;
      if (fl[1] == 1 && mf[1] == 0) setv += 2;
      if (se == 1) setv += 4;
      if (le == 1) setv += 8;
      if (te == 1) setv += 64;
      m_st = (clr ? 0 : m_st) | setv;
      if (m_wk == 1) begin
        if (tick) begin
          if (m_pc == PL - 1) begin m_wk = 0; m_pc = 0; end else m_pc++;
        end
      end else if (setv != 0) begin m_wk = 1; m_pc = 0; end
      if (mf[2] == 0) begin m_hold = 0; m_ldone = 0; end
      else if (le == 1) m_ldone = 1;
      else if (tick && m_ldone == 0) m_hold++;
      for (int i = 0; i < 3; i++) begin
        if (s2[i] == mf[i]) mc[i] = 0;
        else if (tick) begin
          if (mc[i] == DB - 1) begin mf[i] = 1 - mf[i]; mc[i] = 0; end else mc[i]++;
        end
      end
      m_tprev = s2[3];
      for (int i = 0; i < 4; i++) begin s2[i] = s1[i]; s1[i] = raw[i]; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (int'(wake) != m_wk) begin
        n_err++;
        $display("FAIL R8 model wake act=%0d exp=%0d t=%0t", wake, m_wk, $time);
      end
      n_chk++;
      if (int'(status) != m_st) begin
        n_err++;
        $display("FAIL R10 model status act=%02h exp=%02h t=%0t", status, m_st, $time);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int ticks);
    repeat (ticks * TDIV) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", int'(status), 0);
    chk("R1 wake", int'(wake), 0);
    rst_n = 1'b1;
    wt(2);
    // R2 glitch shorter than debounce
    btn = 1'b1; wt(10); btn = 1'b0; wt(40);
    chk("R2 glitch status", int'(status), 0);
    chk("R2 glitch wake", int'(wake), 0);
    // R3 jig active low, R8 pulse
    jig_n = 1'b0; wt(32);
    chk("R3 jig bit", int'(status), 8'h02);
    chk("R8 wake high", int'(wake), 1);
    wt(15);
    chk("R8 wake ended", int'(wake), 0);
    jig_n = 1'b1; wt(40);
    pulse_clr();
    chk("R10 clear", int'(status), 0);
    // R4 spare active low (default)
    spare = 1'b0; wt(40);
    chk("R4 active-low spare", int'(status), 8'h01);
    // switch polarity while staying inactive
    @(negedge clk) begin spare = 1'b1; act_low = 1'b0; end
    spare = 1'b0;
    wt(40); pulse_clr(); wt(2);
    chk("R4 inactive after polarity change", int'(status), 0);
    spare = 1'b1; wt(40);
    chk("R4 active-high spare", int'(status), 8'h01);
    spare = 1'b0; wt(40); pulse_clr();
    // R5 short press
    btn = 1'b1; wt(150);
    chk("R5 no bit while held", int'(status[2]), 0);
    btn = 1'b0; wt(40);
    chk("R5 short press", int'(status), 8'h04);
    pulse_clr();
    // R6 long press
    btn = 1'b1; wt(DB + LG + 10);
    chk("R6 long while held", int'(status), 8'h08);
    btn = 1'b0; wt(40);
    chk("R6 no short on release", int'(status), 8'h08);
    pulse_clr(); wt(20);
    // R7 thermal edge
    therm = 1'b1; repeat (5) @(negedge clk);
    chk("R7 thermal bit", int'(status), 8'h40);
    chk("R7 thermal wake", int'(wake), 1);
    wt(20); pulse_clr();
    // R9 event during pulse does not extend
    jig_n = 1'b0;
    while (!wake) @(negedge clk);
    w = 0;
    wt(2); w += 2 * TDIV;
    therm = 1'b0; repeat (4) @(negedge clk); w += 4;
    therm = 1'b1;
    while (wake) begin @(negedge clk); w++; end
    chk("R9 pulse not extended", (w >= 36 && w <= 41) ? 1 : 0, 1);
    chk("R9 status both", int'(status), 8'h42);
    jig_n = 1'b1; wt(40);
    // R10 set wins over clear in same cycle
    therm = 1'b0; wt(3);
    @(negedge clk) therm = 1'b1;
    @(negedge clk);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    chk("R10 set over clear", int'(status), 8'h40);
    wt(20);
    finish_run();
  end
endmodule